// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block is an up-counting timer with three compare channels, a rollover flag and a single level interrupt. A host reaches it through a plain synchronous register bus. A write takes effect at the clock edge on which `bus_we` is high. A read is combinational: `bus_rdata` always shows the word at `bus_addr`. The bus has no handshake and accepts a write on every cycle, so it never applies back-pressure. The counter advances on source ticks, which arrive as single-cycle enable pulses for a main clock and for a slow clock. Control selects the tick source, and a prescaler divides the selected source.

Two counting modes exist. Free-run lets the counter wrap through all-ones. Restart ties the counter to compare channel 1: a match there reloads zero on the following step, and a write to that compare register zeroes the count at once. An enable-mode bit decides whether enabling the timer starts from zero or resumes from the held value. A self-clearing software-reset bit returns the block to its reset state. It keeps the control fields that are not related to enabling.

Top module: `gp_cmp_timer`

## Requirements
- R1: The register offsets are 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4, 5 and 6 for compare 1, 2 and 3, 7 and 8 for capture 1 and 2, and 9 for the counter. The capture registers, the counter and any offset from 10 to 15 ignore writes. The capture registers and offsets 10 to 15 read zero.
- R2: Control bits 8:6 select the tick source. Code 1 and code 2 use `tick_main`, code 4 uses `tick_slow`, and every other code stops the counter.
- R3: The prescaler keeps bits 11:0 of a write. While the timer is enabled, the counter steps once per PR+1 selected ticks and only ever moves by +1 or to zero.
- R4: A status write clears each of bits 5:0 written as 1 and leaves the others unchanged. Status flags never fall otherwise, except through software reset. When a flag is set in the same cycle as a clear, the set wins.
- R5: The interrupt enable keeps bits 5:0. `irq` is high exactly when (status AND enable) is nonzero and control bit 0 (enable) is 1.
- R6: When a counter step lands on a value equal to compare N, status bit N-1 is set (bits 0 to 2). A step from all-ones sets status bit 5 (rollover). Status bits 3 and 4 are never set.
- R7: In restart mode (control bit 9 = 0), a write to compare 1 zeroes the counter on the next edge, and a step taken while the counter equals compare 1 goes to zero. In free-run mode (bit 9 = 1), neither event disturbs the count.
- R8: After reset, control, prescaler, status, interrupt enable and counter read zero, and the three compare registers read all-ones.
- R9: A control write with bit 15 set performs reset, with one exception: control takes the written value with bits 5:0 forced to zero.
- R10: Control bits 2, 4, 10 to 14 and 15 are never stored and read zero. All other bits read back as written.
- R11: With enable clear, the counter holds its value. A 0-to-1 write of enable with bit 1 (enable mode) set zeroes the counter and the prescale phase. Without bit 1, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_main | input | 1 | Main-source tick pulse |
| tick_slow | input | 1 | Slow-source tick pulse |
| irq | output | 1 | Level interrupt |

## Verification
The collision of most interest is a status clear written in the same cycle that a counter step sets a compare or rollover flag. A related collision is a zeroing write (compare 1 in restart mode, or enable with enable-mode) landing on a cycle with a counter step. The bench provokes the first case by forcing a tick every cycle with a compare sitting a few counts ahead, then issuing clear-all writes on consecutive cycles across the match. Its behavioural model applies the rules "step first, then writes override the count, set beats clear", and every cycle it compares the read-back word and the interrupt with the model.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_PRE  = 1;
  localparam int unsigned OFF_STAT = 2;
  localparam int unsigned OFF_IEN  = 3;
  localparam int unsigned OFF_CMP1 = 4;
  localparam int unsigned OFF_CAP1 = 7;
  localparam int unsigned OFF_CAP2 = 8;
  localparam int unsigned OFF_CNT  = 9;

  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_ENMOD  = 1;
  localparam int unsigned B_SRC_LO = 6;
  localparam int unsigned B_FRR    = 9;
  localparam int unsigned B_SWR    = 15;

  localparam int unsigned FLAG_W = 6;
  localparam int unsigned F_ROV  = 5;

  localparam logic [31:0] CTRL_DROP    = 32'h0000_FC14;
  localparam logic [31:0] CTRL_SWR_CLR = 32'h0000_003F;

  localparam logic [2:0] SRC_MAIN    = 3'b001;
  localparam logic [2:0] SRC_MAIN_HF = 3'b010;
  localparam logic [2:0] SRC_SLOW    = 3'b100;
endpackage

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2:0]       src,
  input  logic             tick_main,
  input  logic             tick_slow,
  input  logic [PRE_W-1:0] div,
  input  logic             clear,
  output logic             step
);
  import gpt_pkg::*;

  logic             src_tick;
  logic [PRE_W-1:0] phase_q;
  logic             at_end;

  always_comb begin
    case (src)
      SRC_MAIN, SRC_MAIN_HF: src_tick = tick_main;
      SRC_SLOW:              src_tick = tick_slow;
      default:               src_tick = 1'b0;
    endcase
  end

  assign at_end = (phase_q >= div);
  assign step   = run & src_tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (clear)            phase_q <= '0;
    else if (run && src_tick)  phase_q <= at_end ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NCH   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step,
  input  logic                      restart,
  input  logic                      clear,
  input  logic [NCH-1:0][CNT_W-1:0] cmp,
  output logic [CNT_W-1:0]          cnt,
  output logic [NCH-1:0]            hit,
  output logic                      wrap
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] adv_val;

  assign adv_val = (restart && cnt_q == cmp[0]) ? '0 : cnt_q + 1'b1;
  assign wrap    = step && (cnt_q == ALL_ONES);
  assign cnt     = cnt_q;

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i] = step && (adv_val == cmp[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step)  cnt_q <= adv_val;
  end
endmodule

// File: rtl/gp_cmp_timer.sv
module gp_cmp_timer #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_main,
  input  logic              tick_slow,
  output logic              irq
);
  import gpt_pkg::*;

  localparam int unsigned NCH = 3;

  logic [31:0]               ctrl_q;
  logic [PRE_W-1:0]          pre_q;
  logic [FLAG_W-1:0]         status_q;
  logic [FLAG_W-1:0]         ien_q;
  logic [NCH-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]          cnt;
  logic [NCH-1:0]            hit;
  logic                      wrap;
  logic                      step;

  logic                      wr_ctrl, wr_pre, wr_stat, wr_ien;
  logic [NCH-1:0]            wr_cmp;
  logic                      soft_rst, en_restart, cmp1_restart, clr_cnt;
  logic [31:0]               ctrl_new;
  logic [FLAG_W-1:0]         clr_bits, set_bits;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_pre  = bus_we && (bus_addr == ADDR_W'(OFF_PRE));
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_ien  = bus_we && (bus_addr == ADDR_W'(OFF_IEN));

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    assign wr_cmp[c] = bus_we && (bus_addr == ADDR_W'(OFF_CMP1 + c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q[c] <= '1;
      else if (soft_rst)  cmp_q[c] <= '1;
      else if (wr_cmp[c]) cmp_q[c] <= bus_wdata[CNT_W-1:0];
    end
  end

  assign ctrl_new     = bus_wdata & ~CTRL_DROP;
  assign soft_rst     = wr_ctrl && bus_wdata[B_SWR];
  assign en_restart   = wr_ctrl && !soft_rst && ctrl_new[B_ENMOD] &&
                        ctrl_new[B_EN] && !ctrl_q[B_EN];
  assign cmp1_restart = wr_cmp[0] && !ctrl_q[B_FRR];
  assign clr_cnt      = soft_rst | en_restart | cmp1_restart;

  gpt_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q[B_EN]),
    .src       (ctrl_q[B_SRC_LO +: 3]),
    .tick_main (tick_main),
    .tick_slow (tick_slow),
    .div       (pre_q),
    .clear     (clr_cnt),
    .step      (step)
  );

  gpt_count_core #(.CNT_W(CNT_W), .NCH(NCH)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .restart (!ctrl_q[B_FRR]),
    .clear   (clr_cnt),
    .cmp     (cmp_q),
    .cnt     (cnt),
    .hit     (hit),
    .wrap    (wrap)
  );

  assign clr_bits = wr_stat ? bus_wdata[FLAG_W-1:0] : '0;

  always_comb begin
    set_bits          = '0;
    set_bits[NCH-1:0] = hit;
    set_bits[F_ROV]   = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pre_q    <= '0;
      status_q <= '0;
      ien_q    <= '0;
    end else if (soft_rst) begin
      ctrl_q   <= ctrl_new & ~CTRL_SWR_CLR;
      pre_q    <= '0;
      status_q <= '0;
      ien_q    <= '0;
    end else begin
      status_q <= (status_q & ~clr_bits) | set_bits;
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (wr_pre)  pre_q  <= bus_wdata[PRE_W-1:0];
      if (wr_ien)  ien_q  <= bus_wdata[FLAG_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL):     bus_rdata = ctrl_q;
      ADDR_W'(OFF_PRE):      bus_rdata = 32'(pre_q);
      ADDR_W'(OFF_STAT):     bus_rdata = 32'(status_q);
      ADDR_W'(OFF_IEN):      bus_rdata = 32'(ien_q);
      ADDR_W'(OFF_CMP1):     bus_rdata = 32'(cmp_q[0]);
      ADDR_W'(OFF_CMP1 + 1): bus_rdata = 32'(cmp_q[1]);
      ADDR_W'(OFF_CMP1 + 2): bus_rdata = 32'(cmp_q[2]);
      ADDR_W'(OFF_CAP1),
      ADDR_W'(OFF_CAP2):     bus_rdata = '0;
      ADDR_W'(OFF_CNT):      bus_rdata = 32'(cnt);
      default:               bus_rdata = '0;
    endcase
  end

  assign irq = (|(status_q & ien_q)) & ctrl_q[B_EN];
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic             wr_swr,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic             ctrl_en,
  input logic             ctrl_frr,
  input logic [5:0]       status,
  input logic [CNT_W-1:0] cnt
);
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > 4'd9 || bus_addr == 4'd7 || bus_addr == 4'd8) |-> bus_rdata == 32'd0); // R1

  AST_STEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(status) & ~status)) |-> $past(bus_we && (bus_addr == 4'd2 || (bus_addr == 4'd0 && wr_swr)))); // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 6'd0)); // R5

  AST_CAP_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    status[4:3] == 2'b00); // R6

  AST_CMP1_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd4 && !ctrl_frr) |=> cnt == '0); // R7

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd0 && wr_swr) |=> (status == 6'd0 && cnt == '0 && !ctrl_en)); // R9

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !bus_we) |=> $stable(cnt)); // R11
endmodule

bind gp_cmp_timer gpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .wr_swr    (bus_wdata[15]),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .ctrl_en   (ctrl_q[0]),
  .ctrl_frr  (ctrl_q[9]),
  .status    (status_q),
  .cnt       (cnt)
);

// File: tb/tb_gp_cmp_timer.sv
`timescale 1ns/1ps
module tb_gp_cmp_timer;
  localparam int CW = 8;
  localparam int unsigned M = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        tick_main = 1'b0;
  logic        tick_slow = 1'b0;
  logic        irq;

  gp_cmp_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_main(tick_main),
    .tick_slow(tick_slow), .irq(irq)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phase = "R8";
  logic [15:0] lf = 16'hACE1;
  bit force_tick = 0;
  int rd_ptr = 0;

  // behavioural reference state
  logic [31:0] m_ctrl;
  int unsigned m_pr, m_cnt, m_pc, nc;
  logic [5:0]  m_st, m_ie, setv, clrv;
  int unsigned m_cmp [3];
  logic        src_tick;
  bit          stp;
  logic [31:0] nv;

  task automatic m_reset();
    m_ctrl = 0; m_pr = 0; m_st = 0; m_ie = 0; m_cnt = 0; m_pc = 0;
    for (int i = 0; i < 3; i++) m_cmp[i] = M;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      case (m_ctrl[8:6])
        3'd1, 3'd2: src_tick = tick_main;
        3'd4:       src_tick = tick_slow;
        default:    src_tick = 1'b0;
      endcase
      stp = 0; setv = 0;
      if (m_ctrl[0] && src_tick) begin
        if (m_pc >= m_pr) begin m_pc = 0; stp = 1; end
        else m_pc = m_pc + 1;
      end
      if (stp) begin
        if (!m_ctrl[9] && m_cnt == m_cmp[0]) nc = 0;
        else nc = (m_cnt + 1) & M;
        for (int i = 0; i < 3; i++) if (nc == m_cmp[i]) setv[i] = 1'b1;
        if (m_cnt == M) setv[5] = 1'b1;
        m_cnt = nc;
      end
      clrv = (bus_we && bus_addr == 4'd2) ? bus_wdata[5:0] : 6'd0;
      m_st = (m_st & ~clrv) | setv;
      if (bus_we) begin
        case (bus_addr)
          4'd0: begin
            nv = bus_wdata & 32'hFFFF_03EB;
            if (bus_wdata[15]) begin
              m_reset();
              m_ctrl = nv & ~32'h3F;
            end else begin
              if (nv[1] && nv[0] && !m_ctrl[0]) begin m_cnt = 0; m_pc = 0; end
              m_ctrl = nv;
            end
          end
          4'd1: m_pr = bus_wdata & 32'hFFF;
          4'd3: m_ie = bus_wdata[5:0];
          4'd4: begin
            m_cmp[0] = bus_wdata & M;
            if (!m_ctrl[9]) begin m_cnt = 0; m_pc = 0; end
          end
          4'd5: m_cmp[1] = bus_wdata & M;
          4'd6: m_cmp[2] = bus_wdata & M;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return m_pr;
      4'd2: return {26'd0, m_st};
      4'd3: return {26'd0, m_ie};
      4'd4: return m_cmp[0];
      4'd5: return m_cmp[1];
      4'd6: return m_cmp[2];
      4'd9: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", phase, what, act, exp, $time);
    end
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic cyc(bit we, logic [3:0] a, logic [31:0] d);
    logic exp_irq;
    @(negedge clk);
    if (rst_n) begin
      chk(bus_rdata == exp_rd(bus_addr), $sformatf("rdata@%0d", bus_addr),
          bus_rdata, exp_rd(bus_addr));
      exp_irq = ((m_st & m_ie) != 0) && m_ctrl[0];
      chk(irq == exp_irq, "irq", {31'd0, irq}, {31'd0, exp_irq});
    end
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    tick_main = force_tick | lf[0] | lf[3];
    tick_slow = force_tick | (lf[5] & lf[7]);
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 4'(rd_ptr), 32'd0);
      rd_ptr = (rd_ptr + 1) % 16;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cyc(1'b1, a, d);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    phase = "R8"; run(32);                       // reset values
    phase = "R1";                                // write-ignored and zero offsets
    for (int a = 7; a < 16; a++) begin wr(4'(a), 32'hDEAD_BEEF); run(17); end
    phase = "R10";
    wr(4'd0, 32'hFFFF_7FFE); run(17); wr(4'd0, 32'h0); run(4);
    phase = "R6";                                // free run, main source
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd4, 32'h10); wr(4'd5, 32'h40); wr(4'd6, 32'h80);
    wr(4'd0, 32'h241);
    for (int k = 0; k < 16; k++) begin run(37); wr(4'd2, 32'h0000_0015); end
    phase = "R3";                                // prescaler, slow source
    wr(4'd1, 32'hFFFF_F002); wr(4'd0, 32'h301); run(600);
    wr(4'd1, 32'h0000_0005); run(300); wr(4'd1, 32'h0); run(50);
    phase = "R2";                                // no-clock codes and the second main code
    wr(4'd0, 32'h2C1); run(100); wr(4'd0, 32'h201); run(60);
    wr(4'd0, 32'h3C1); run(60); wr(4'd0, 32'h281); run(200);
    phase = "R5";                                // interrupt mask and enable gating
    wr(4'd3, 32'h1); run(40); wr(4'd3, 32'h20); run(300);
    wr(4'd0, 32'h280); run(20); wr(4'd0, 32'h281); wr(4'd3, 32'h3F); run(20);
    phase = "R7";                                // restart mode on compare 1
    wr(4'd0, 32'h041); wr(4'd4, 32'h20); run(300);
    wr(4'd4, 32'h08); run(5); wr(4'd4, 32'h30); run(200);
    wr(4'd0, 32'h241); wr(4'd4, 32'h10); run(300);
    phase = "R4";                                // clear colliding with a set
    force_tick = 1;
    wr(4'd0, 32'h041); wr(4'd5, 32'h06); wr(4'd4, 32'hF0);
    for (int k = 0; k < 12; k++) wr(4'd2, 32'h3F);
    run(20);
    wr(4'd4, 32'hF0);
    for (int k = 0; k < 12; k++) wr(4'd2, 32'h02);
    force_tick = 0;
    phase = "R11";                               // hold, resume and enable-mode restart
    wr(4'd0, 32'h240); run(30); wr(4'd0, 32'h241); run(40);
    wr(4'd0, 32'h240); run(10); wr(4'd0, 32'h243); run(40);
    wr(4'd0, 32'h243); run(20);
    phase = "R9";                                // software reset keeps other control fields
    wr(4'd1, 32'h7); wr(4'd3, 32'h3F);
    wr(4'd0, 32'h0001_82FF); run(40);
    wr(4'd0, 32'h241); run(100);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog %s actual=hung expected=finished", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule